// File: doc/BRIEF.md
# Processor Low-Power State Sequencer

This block follows a processor core through its low-power ladder and drives the requests that go with each rung. It watches five active-low control inputs: stop-clock grant, sleep, deep sleep, reference-clock halt and core reset. It also watches one active-high voltage-lowering request. From these inputs it moves between a running state, a granted-stop state, a sleep state, a deep state and a deeper low-voltage state. After deep sleep it passes through a timed relock state, in which the PLL is given a fixed number of reference-clock cycles to settle before the core counts as asleep again.

Each state may be left only toward its neighbour on the ladder. Core reset bypasses the ladder from any state. Once the core is asleep, any input change that is not a legal move for the current state sets a sticky error flag. The block supplies four signals: a snoop/interrupt acceptance enable, a request to stop the reference clock, and a request for the regulator to lower the core voltage, plus the error flag. Every control input passes through a two-flop synchronizer. All outputs come from registers.

Top module: `sleep_seq_ctrl`

## Requirements
- R1: While `rst` is high and afterwards until an input changes, `state_o` is 0, `accept_en` is 1, and `clk_stop_req`, `low_volt_req` and `seq_err` are 0.
- R2: The state codes are: running 0, granted-stop 1, sleep 2, deep 3, deeper 4, relock 5, reset-hold 6. Asserting `hold_n` in running moves to granted-stop, and releasing it moves back. Asserting `doze_n` in granted-stop moves to sleep, and releasing `doze_n` in sleep returns to granted-stop.
- R3: Deep is entered only from sleep, when `deep_n` and `halt_n` are both asserted. Asserting them in granted-stop causes no move. `clk_stop_req` is 1 exactly in deep and deeper.
- R4: Releasing `deep_n` and `halt_n` together in deep moves to relock. Relock lasts exactly PLL_CYCLES clock cycles and then moves to sleep. `clk_stop_req` is 0 in relock.
- R5: Asserting `deep_n` and `halt_n` again during relock returns to deep. A later relock waits the full PLL_CYCLES again.
- R6: `volt_low_req` high in deep moves to deeper, where `low_volt_req` is 1. Dropping it returns to deep, where `low_volt_req` is 0. Releasing `deep_n`/`halt_n` in deeper causes no move and sets `seq_err`.
- R7: `accept_en` is 1 in running and granted-stop, and 0 in sleep, deep, deeper, relock and reset-hold.
- R8: In sleep, deep, deeper or relock, an input change that is not a legal move sets `seq_err`. In sleep, a change of `volt_low_req` is one such change. `seq_err` stays 1 until `rst`. A fully legal sequence leaves it 0.
- R9: Asserting `core_rst_n` in any state moves to reset-hold, and releasing it moves to running. If `hold_n` or `doze_n` is still asserted after the first reset-hold cycle, `seq_err` is set. Releasing both together with the reset assertion leaves it clear.
- R10: A change on any control input shows on the outputs after exactly three rising clock edges: two synchronizer stages and the output register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high block reset |
| hold_n | input | 1 | Stop-clock grant, active low |
| doze_n | input | 1 | Sleep request, active low |
| deep_n | input | 1 | Deep-sleep request, active low |
| halt_n | input | 1 | Reference-clock halt, active low, paired with deep_n |
| core_rst_n | input | 1 | Core reset, active low |
| volt_low_req | input | 1 | Request to drop to the low-voltage state |
| state_o | output | 3 | Current state code |
| accept_en | output | 1 | Snoops and interrupts may be accepted |
| clk_stop_req | output | 1 | Request to stop the reference clock |
| low_volt_req | output | 1 | Request to the regulator for lowered core voltage |
| seq_err | output | 1 | Sticky illegal-transition flag |

## Verification
Every result appears three rising edges after the input is driven. The bench drives inputs on falling edges and samples one falling edge after the third rising edge. One check samples after only two edges to confirm the old value is still present there. The relock window is counted from the third edge after release. It is swept cycle by cycle: the state must read relock on each of the PLL_CYCLES samples and read sleep on the next one. The reset-hold error appears two edges after reset-hold is entered, so the bench samples it five edges after the stimulus, with a margin cycle.

// File: rtl/sleep_seq_pkg.sv
package sleep_seq_pkg;

  typedef enum logic [2:0] {
    ST_RUN     = 3'd0,
    ST_GRANT   = 3'd1,
    ST_NAP     = 3'd2,
    ST_DEEP    = 3'd3,
    ST_DEEPER  = 3'd4,
    ST_RELOCK  = 3'd5,
    ST_RSTHOLD = 3'd6
  } pstate_t;

  // control inputs, active high after inversion
  typedef struct packed {
    logic vlow;
    logic rst;
    logic halt;
    logic deep;
    logic doze;
    logic hold;
  } ctl_t;

  localparam int CTL_W = $bits(ctl_t);

endpackage

// File: rtl/sleep_sync.sv
module sleep_sync #(
  parameter int W      = 6,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] stg_q [STAGES];

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) stg_q[g] <= '0;
          else     stg_q[g] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) stg_q[g] <= '0;
          else     stg_q[g] <= stg_q[g-1];
        end
      end
    end
  endgenerate

  assign q = stg_q[STAGES-1];

endmodule

// File: rtl/sleep_relock_timer.sv
module sleep_relock_timer #(
  parameter int PLL_CYCLES = 3000
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic done
);

  localparam int CW = (PLL_CYCLES < 2) ? 1 : $clog2(PLL_CYCLES + 1);
  localparam logic [CW-1:0] LAST = CW'(PLL_CYCLES - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || !run) cnt_q <= '0;
    else if (cnt_q != LAST) cnt_q <= cnt_q + 1'b1;
  end

  assign done = run && (cnt_q == LAST);

  a_r4_done_only_in_relock: assert property (@(posedge clk) disable iff (rst)
    done |-> run);

  a_r5_count_cleared_outside: assert property (@(posedge clk) disable iff (rst)
    !run |=> (cnt_q == '0));

  a_r4_count_bounded: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= LAST);

endmodule

// File: rtl/sleep_fsm.sv
module sleep_fsm
  import sleep_seq_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  ctl_t    cur,
  input  logic    relock_done,
  output logic    relock_run,
  output pstate_t state_q,
  output logic    accept_q,
  output logic    clkstop_q,
  output logic    lowv_q,
  output logic    err_q
);

  ctl_t    prv_q;
  ctl_t    chg;
  logic    was_rh_q;
  logic    pair_ok;
  logic    bad;
  pstate_t nxt;

  assign chg        = cur ^ prv_q;
  assign pair_ok    = (cur.deep == cur.halt);
  assign relock_run = (state_q == ST_RELOCK);

  always_comb begin
    nxt = state_q;
    if (cur.rst) begin
      nxt = ST_RSTHOLD;
    end else begin
      unique case (state_q)
        ST_RUN:     if (cur.hold) nxt = ST_GRANT;
        ST_GRANT:   if (!cur.hold) nxt = ST_RUN;
                    else if (cur.doze) nxt = ST_NAP;
        ST_NAP:     if (!cur.doze) nxt = ST_GRANT;
                    else if (cur.deep && cur.halt) nxt = ST_DEEP;
        ST_DEEP:    if (!cur.deep && !cur.halt) nxt = ST_RELOCK;
                    else if (cur.vlow) nxt = ST_DEEPER;
        ST_DEEPER:  if (!cur.vlow) nxt = ST_DEEP;
        ST_RELOCK:  if (cur.deep && cur.halt) nxt = ST_DEEP;
                    else if (relock_done) nxt = ST_NAP;
        ST_RSTHOLD: nxt = ST_RUN;
        default:    nxt = ST_RUN;
      endcase
    end
  end

  always_comb begin
    bad = 1'b0;
    unique case (state_q)
      ST_NAP:     bad = !cur.rst && (chg.hold || chg.vlow || !pair_ok);
      ST_DEEP:    bad = !cur.rst && (chg.hold || chg.doze || !pair_ok);
      ST_DEEPER:  bad = !cur.rst && (chg.hold || chg.doze || chg.deep || chg.halt);
      ST_RELOCK:  bad = !cur.rst && (chg.hold || chg.doze || chg.vlow || !pair_ok);
      ST_RSTHOLD: bad = was_rh_q && (cur.hold || cur.doze);
      default:    bad = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= ST_RUN;
      prv_q     <= '0;
      was_rh_q  <= 1'b0;
      accept_q  <= 1'b1;
      clkstop_q <= 1'b0;
      lowv_q    <= 1'b0;
      err_q     <= 1'b0;
    end else begin
      state_q   <= nxt;
      prv_q     <= cur;
      was_rh_q  <= (state_q == ST_RSTHOLD);
      accept_q  <= (nxt == ST_RUN) || (nxt == ST_GRANT);
      clkstop_q <= (nxt == ST_DEEP) || (nxt == ST_DEEPER);
      lowv_q    <= (nxt == ST_DEEPER);
      err_q     <= err_q | bad;
    end
  end

  a_r2_nap_entry: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_NAP && $past(state_q) != ST_NAP)
      |-> ($past(state_q) == ST_GRANT || $past(state_q) == ST_RELOCK));

  a_r3_deep_entry: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_DEEP && $past(state_q) != ST_DEEP)
      |-> ($past(state_q) inside {ST_NAP, ST_DEEPER, ST_RELOCK}));

  a_r6_deeper_entry: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_DEEPER && $past(state_q) != ST_DEEPER)
      |-> ($past(state_q) == ST_DEEP));

  a_r7_no_accept_asleep: assert property (@(posedge clk) disable iff (rst)
    (state_q inside {ST_NAP, ST_DEEP, ST_DEEPER, ST_RELOCK, ST_RSTHOLD}) |-> !accept_q);

  a_r8_err_sticky: assert property (@(posedge clk) disable iff (rst)
    err_q |=> err_q);

  a_r9_reset_bypass: assert property (@(posedge clk) disable iff (rst)
    cur.rst |=> (state_q == ST_RSTHOLD));

endmodule

// File: rtl/sleep_seq_ctrl.sv
module sleep_seq_ctrl
  import sleep_seq_pkg::*;
#(
  parameter int PLL_CYCLES  = 3000,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       hold_n,
  input  logic       doze_n,
  input  logic       deep_n,
  input  logic       halt_n,
  input  logic       core_rst_n,
  input  logic       volt_low_req,
  output logic [2:0] state_o,
  output logic       accept_en,
  output logic       clk_stop_req,
  output logic       low_volt_req,
  output logic       seq_err
);

  ctl_t       raw;
  ctl_t       cur;
  logic [CTL_W-1:0] sync_q;
  logic       run;
  logic       done;
  pstate_t    st;

  always_comb begin
    raw.hold = ~hold_n;
    raw.doze = ~doze_n;
    raw.deep = ~deep_n;
    raw.halt = ~halt_n;
    raw.rst  = ~core_rst_n;
    raw.vlow = volt_low_req;
  end

  sleep_sync #(.W(CTL_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (raw),
    .q   (sync_q)
  );

  assign cur = ctl_t'(sync_q);

  sleep_relock_timer #(.PLL_CYCLES(PLL_CYCLES)) u_timer (
    .clk  (clk),
    .rst  (rst),
    .run  (run),
    .done (done)
  );

  sleep_fsm u_fsm (
    .clk         (clk),
    .rst         (rst),
    .cur         (cur),
    .relock_done (done),
    .relock_run  (run),
    .state_q     (st),
    .accept_q    (accept_en),
    .clkstop_q   (clk_stop_req),
    .lowv_q      (low_volt_req),
    .err_q       (seq_err)
  );

  assign state_o = st;

endmodule

// File: tb/sleep_seq_ctrl_tb.sv
module sleep_seq_ctrl_tb_top;

  localparam int P = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic hold_n = 1'b1, doze_n = 1'b1, deep_n = 1'b1, halt_n = 1'b1;
  logic core_rst_n = 1'b1, volt_low_req = 1'b0;
  logic [2:0] state_o;
  logic accept_en, clk_stop_req, low_volt_req, seq_err;

  int n_run = 0;
  int n_fail = 0;
  bit done_flag = 1'b0;

  always #5 clk = ~clk;

  sleep_seq_ctrl #(.PLL_CYCLES(P), .SYNC_STAGES(2)) dut_i (
    .clk(clk), .rst(rst), .hold_n(hold_n), .doze_n(doze_n), .deep_n(deep_n),
    .halt_n(halt_n), .core_rst_n(core_rst_n), .volt_low_req(volt_low_req),
    .state_o(state_o), .accept_en(accept_en), .clk_stop_req(clk_stop_req),
    .low_volt_req(low_volt_req), .seq_err(seq_err)
  );

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string tag, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic block_reset();
    hold_n = 1; doze_n = 1; deep_n = 1; halt_n = 1; core_rst_n = 1; volt_low_req = 0;
    rst = 1; step(4); rst = 0; step(1);
  endtask

  task automatic go_sleep();
    hold_n = 0; step(3);
    doze_n = 0; step(3);
  endtask

  task automatic finish_run();
    if (!done_flag) begin
      done_flag = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    finish_run();
  end

  initial begin
    @(negedge clk);
    step(3);
    // R1 state during reset
    chk("R1 state in reset", state_o, 0);
    chk("R1 accept in reset", accept_en, 1);
    rst = 0; step(2);
    chk("R1 outputs after reset", {clk_stop_req, low_volt_req, seq_err}, 0);

    // R10 latency and R2 grant
    hold_n = 0; step(2);
    chk("R10 old value after two edges", state_o, 0);
    step(1);
    chk("R10/R2 granted after three edges", state_o, 1);
    chk("R7 accept in granted", accept_en, 1);
    hold_n = 1; step(3);
    chk("R2 back to running", state_o, 0);
    hold_n = 0; step(3);

    // R3 deep ignored outside sleep
    deep_n = 0; halt_n = 0; step(4);
    chk("R3 deep ignored in granted", state_o, 1);
    chk("R3 no clock stop in granted", clk_stop_req, 0);
    deep_n = 1; halt_n = 1; step(3);

    doze_n = 0; step(3);
    chk("R2 sleep entered", state_o, 2);
    chk("R7 accept low in sleep", accept_en, 0);
    doze_n = 1; step(3);
    chk("R2 sleep exit to granted", state_o, 1);
    doze_n = 0; step(3);

    // R3 deep entry
    deep_n = 0; halt_n = 0; step(3);
    chk("R3 deep entered", state_o, 3);
    chk("R3 clock stop in deep", clk_stop_req, 1);
    chk("R7 accept low in deep", accept_en, 0);

    // R6 deeper
    volt_low_req = 1; step(3);
    chk("R6 deeper entered", state_o, 4);
    chk("R6 low voltage in deeper", low_volt_req, 1);
    chk("R3 clock stop in deeper", clk_stop_req, 1);
    volt_low_req = 0; step(3);
    chk("R6 back to deep", state_o, 3);
    chk("R6 low voltage dropped", low_volt_req, 0);

    // R4 relock sweep
    deep_n = 1; halt_n = 1; step(3);
    chk("R4 clock stop off in relock", clk_stop_req, 0);
    chk("R7 accept low in relock", accept_en, 0);
    for (int k = 0; k < P; k++) begin
      chk("R4 relock held", state_o, 5);
      step(1);
    end
    chk("R4 sleep after relock", state_o, 2);

    // R5 re-entry during relock restarts wait
    deep_n = 0; halt_n = 0; step(3);
    deep_n = 1; halt_n = 1; step(3);
    chk("R5 in relock", state_o, 5);
    deep_n = 0; halt_n = 0; step(3);
    chk("R5 back to deep", state_o, 3);
    deep_n = 1; halt_n = 1; step(3);
    step(P - 1);
    chk("R5 full wait restarted", state_o, 5);
    step(1);
    chk("R5 sleep after full wait", state_o, 2);
    chk("R8 legal sequence no error", seq_err, 0);

    // R8 illegal change in sleep, sticky
    volt_low_req = 1; step(3);
    chk("R8 error on vlow in sleep", seq_err, 1);
    volt_low_req = 0; step(6);
    chk("R8 error sticky", seq_err, 1);
    chk("R8 state unchanged", state_o, 2);

    // R9 clean reset bypass
    block_reset();
    chk("R8 error cleared by rst", seq_err, 0);
    go_sleep();
    core_rst_n = 0; hold_n = 1; doze_n = 1; step(3);
    chk("R9 reset-hold entered", state_o, 6);
    chk("R7 accept low in reset-hold", accept_en, 0);
    step(3);
    chk("R9 clean release no error", seq_err, 0);
    core_rst_n = 1; step(3);
    chk("R9 running after reset", state_o, 0);

    // R9 late release sets error
    block_reset();
    go_sleep();
    core_rst_n = 0; step(6);
    chk("R9 late release error", seq_err, 1);
    chk("R9 state reset-hold", state_o, 6);

    // R6 illegal exit from deeper
    block_reset();
    go_sleep();
    deep_n = 0; halt_n = 0; step(3);
    volt_low_req = 1; step(3);
    deep_n = 1; halt_n = 1; step(4);
    chk("R6 no exit from deeper", state_o, 4);
    chk("R6 error on deeper exit", seq_err, 1);

    finish_run();
  end

endmodule